// File: doc/BRIEF.md
# Two-phase 64-bit fence descriptor commit sequencer

This block writes a 64-bit fence descriptor into a target register that can only be reached through a 32-bit bus. That bus cannot write both halves at once, and it offers a read whose response acts as a completion barrier. A half-written descriptor with its valid bit set must never be visible to the target. On each commit the block first switches the fence off by writing zero to its low word and waits on a read-back of that word. It then writes the upper half, and then the lower half, which carries the valid bit. A last read-back closes the sequence. A descriptor of zero uses the same sequence and leaves the fence cleared.

The block keeps a shadow copy of the last descriptor committed to each fence. It also keeps a pending flag per fence, which is set when a commit is taken and cleared when that commit's sequence ends. A restore request makes the block rewrite every fence from the shadow copy, in ascending index order. This is used after the target has lost its state, for example after a reset or a resume.

Top module: `fence_commit_seq`

## Requirements
- R1: Immediately after reset, req_ready is 1, bus_cmd_valid is 0, done and restore_done are 0, and dirty_mask is all zeros.
- R2: A commit is taken only on a cycle where req_valid and req_ready are both 1. req_ready stays 0 from that cycle until the done pulse that ends the sequence. During a restore it stays 0 until restore_done.
- R3: The first bus command after a commit is taken is a write (bus_cmd_write=1) of zero to the low-word address BASE_ADDR + 8*index + 4.
- R4: The second command is a read (bus_cmd_write=0) of the low-word address. After any read is accepted, bus_cmd_valid stays 0 until bus_rsp_valid has been seen.
- R5: After the first read response, the block writes descriptor bits 63:32 to the high-word address BASE_ADDR + 8*index. It then writes descriptor bits 31:0 to the low-word address.
- R6: The fifth command is a read of the low-word address. One cycle after its response is taken, done pulses for one cycle with done_index equal to the fence index.
- R7: While bus_cmd_valid is 1 and bus_cmd_ready is 0, the command's valid, write flag, address and data hold unchanged on the next cycle.
- R8: Bit index of dirty_mask is set on the cycle after a commit to that index is taken. It reads 0 in the cycle where done pulses for that index.
- R9: A commit with a descriptor of zero runs the full five-command sequence, and both of its descriptor writes carry zero.
- R10: A restore (restore_req while req_ready is 1) runs the five-command sequence for every index from 0 up to NUM_FENCES-1, in order, using the last committed descriptor of each. restore_done pulses together with the last fence's done. A restore takes priority over a commit requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Commit request |
| req_ready | output | 1 | Block idle, request or restore can be taken |
| req_index | input | IDX_W | Fence to commit |
| req_desc | input | 2*BUS_W | Descriptor to commit (zero clears) |
| restore_req | input | 1 | Rewrite all fences from the shadow copy |
| bus_cmd_valid | output | 1 | Bus command present |
| bus_cmd_ready | input | 1 | Bus accepts the command |
| bus_cmd_write | output | 1 | 1 = write, 0 = barrier read |
| bus_cmd_addr | output | ADDR_W | Byte address of the 32-bit word |
| bus_cmd_wdata | output | BUS_W | Write data |
| bus_rsp_valid | input | 1 | Read response (barrier completion) |
| done | output | 1 | One-cycle pulse at the end of a fence sequence |
| done_index | output | IDX_W | Fence that just finished |
| restore_done | output | 1 | One-cycle pulse at the end of a restore pass |
| dirty_mask | output | NUM_FENCES | Per-fence pending flag |

## Verification
The assertions take for granted that bus_rsp_valid only arrives while a barrier read is outstanding, and only once for each read. They also take for granted that restore_req is raised only after every fence has been committed at least once, so that no shadow entry is undefined. The bench's bus responder raises a single response pulse, with a chosen delay, only after it has seen a read accepted. The tests commit all four fences before they request any restore. Ready stalls from a pseudo-random pattern test the hold rule without breaking either assumption.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_CMD,
    ST_RSP
  } fcs_state_e;

  typedef enum logic [2:0] {
    OP_OFF,
    OP_BAR1,
    OP_HI,
    OP_LO,
    OP_BAR2
  } fcs_op_e;
endpackage

// File: rtl/fcs_addr_gen.sv
module fcs_addr_gen #(
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 2,
  parameter int BASE_ADDR = 'h4000
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] hi_addr,
  output logic [ADDR_W-1:0] lo_addr
);
  localparam int STRIDE_SH = 3;
  localparam logic [ADDR_W-1:0] LO_OFS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(BASE_ADDR);

  always_comb begin
    hi_addr = BASE + (ADDR_W'(idx) << STRIDE_SH);
    lo_addr = hi_addr + LO_OFS;
  end
endmodule

// File: rtl/fcs_shadow_ram.sv
module fcs_shadow_ram #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int NUM_FENCES = 4,
  parameter int IDX_W      = 2,
  parameter int BUS_W      = 32,
  parameter int ADDR_W     = 16,
  parameter int BASE_ADDR  = 'h4000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [IDX_W-1:0]     req_index,
  input  logic [2*BUS_W-1:0]   req_desc,
  input  logic                 restore_req,
  output logic                 commit_take,
  output logic [IDX_W-1:0]     ram_raddr,
  input  logic [2*BUS_W-1:0]   ram_rdata,
  output logic                 bus_cmd_valid,
  input  logic                 bus_cmd_ready,
  output logic                 bus_cmd_write,
  output logic [ADDR_W-1:0]    bus_cmd_addr,
  output logic [BUS_W-1:0]     bus_cmd_wdata,
  input  logic                 bus_rsp_valid,
  output logic                 fin,
  output logic [IDX_W-1:0]     fin_index,
  output logic                 done,
  output logic [IDX_W-1:0]     done_index,
  output logic                 restore_done
);
  localparam int DESC_W = 2 * BUS_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FENCES - 1);

  fcs_state_e        state_q;
  fcs_op_e           op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DESC_W-1:0] desc_q;
  logic              restoring_q;
  logic              cmd_valid_q;
  logic [BUS_W-1:0]  wdata_q;
  logic              done_q;
  logic [IDX_W-1:0]  done_idx_q;
  logic              rdone_q;
  logic [ADDR_W-1:0] hi_addr, lo_addr;
  logic              take_restore, cmd_fire;

  fcs_addr_gen #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)
  ) u_addr (
    .idx(idx_q), .hi_addr(hi_addr), .lo_addr(lo_addr)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign take_restore  = req_ready && restore_req;
  assign commit_take   = req_ready && req_valid && !restore_req;
  assign cmd_fire      = cmd_valid_q && bus_cmd_ready;
  assign ram_raddr     = idx_q;
  assign bus_cmd_valid = cmd_valid_q;
  assign bus_cmd_write = (op_q == OP_OFF) || (op_q == OP_HI) || (op_q == OP_LO);
  assign bus_cmd_addr  = (op_q == OP_HI) ? hi_addr : lo_addr;
  assign bus_cmd_wdata = wdata_q;
  assign fin           = (state_q == ST_RSP) && bus_rsp_valid && (op_q == OP_BAR2);
  assign fin_index     = idx_q;
  assign done          = done_q;
  assign done_index    = done_idx_q;
  assign restore_done  = rdone_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_OFF;
      idx_q       <= '0;
      desc_q      <= '0;
      restoring_q <= 1'b0;
      cmd_valid_q <= 1'b0;
      wdata_q     <= '0;
      done_q      <= 1'b0;
      done_idx_q  <= '0;
      rdone_q     <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      rdone_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take_restore) begin
            restoring_q <= 1'b1;
            idx_q       <= '0;
            state_q     <= ST_FETCH;
          end else if (commit_take) begin
            idx_q       <= req_index;
            desc_q      <= req_desc;
            op_q        <= OP_OFF;
            wdata_q     <= '0;
            cmd_valid_q <= 1'b1;
            state_q     <= ST_CMD;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          desc_q      <= ram_rdata;
          op_q        <= OP_OFF;
          wdata_q     <= '0;
          cmd_valid_q <= 1'b1;
          state_q     <= ST_CMD;
        end
        ST_CMD: begin
          if (cmd_fire) begin
            case (op_q)
              OP_OFF:  op_q <= OP_BAR1;
              OP_HI: begin
                op_q    <= OP_LO;
                wdata_q <= desc_q[BUS_W-1:0];
              end
              OP_LO: begin
                op_q    <= OP_BAR2;
                wdata_q <= '0;
              end
              default: begin
                cmd_valid_q <= 1'b0;
                state_q     <= ST_RSP;
              end
            endcase
          end
        end
        ST_RSP: begin
          if (bus_rsp_valid) begin
            if (op_q == OP_BAR1) begin
              op_q        <= OP_HI;
              wdata_q     <= desc_q[DESC_W-1:BUS_W];
              cmd_valid_q <= 1'b1;
              state_q     <= ST_CMD;
            end else begin
              done_q     <= 1'b1;
              done_idx_q <= idx_q;
              if (restoring_q && (idx_q != LAST_IDX)) begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_FETCH;
              end else begin
                rdone_q     <= restoring_q;
                restoring_q <= 1'b0;
                state_q     <= ST_IDLE;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_valid && !bus_cmd_ready) |=> (bus_cmd_valid && $stable(bus_cmd_write)
      && $stable(bus_cmd_addr) && $stable(bus_cmd_wdata)));

  // R3
  first_off_chk: assert property (@(posedge clk) disable iff (rst)
    commit_take |=> (bus_cmd_valid && bus_cmd_write && bus_cmd_wdata == '0
      && bus_cmd_addr == lo_addr));

  // R4
  barrier_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_valid && bus_cmd_ready && !bus_cmd_write) |=> !bus_cmd_valid);

  // R6
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_rsp_valid));

  // R2
  idle_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_cmd_valid);
endmodule

// File: rtl/fence_commit_seq.sv
module fence_commit_seq #(
  parameter int NUM_FENCES = 4,
  parameter int BUS_W      = 32,
  parameter int ADDR_W     = 16,
  parameter int BASE_ADDR  = 'h4000,
  localparam int IDX_W     = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1,
  localparam int DESC_W    = 2 * BUS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [IDX_W-1:0]      req_index,
  input  logic [DESC_W-1:0]     req_desc,
  input  logic                  restore_req,
  output logic                  bus_cmd_valid,
  input  logic                  bus_cmd_ready,
  output logic                  bus_cmd_write,
  output logic [ADDR_W-1:0]     bus_cmd_addr,
  output logic [BUS_W-1:0]      bus_cmd_wdata,
  input  logic                  bus_rsp_valid,
  output logic                  done,
  output logic [IDX_W-1:0]      done_index,
  output logic                  restore_done,
  output logic [NUM_FENCES-1:0] dirty_mask
);
  logic              commit_take;
  logic [IDX_W-1:0]  ram_raddr;
  logic [DESC_W-1:0] ram_rdata;
  logic              fin;
  logic [IDX_W-1:0]  fin_index;
  logic [NUM_FENCES-1:0] dirty_q;

  fcs_shadow_ram #(
    .DEPTH(NUM_FENCES), .AW(IDX_W), .DW(DESC_W)
  ) u_shadow (
    .clk(clk), .we(commit_take), .waddr(req_index), .wdata(req_desc),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  fcs_seq #(
    .NUM_FENCES(NUM_FENCES), .IDX_W(IDX_W), .BUS_W(BUS_W),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_desc(req_desc), .restore_req(restore_req),
    .commit_take(commit_take), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd_ready(bus_cmd_ready),
    .bus_cmd_write(bus_cmd_write), .bus_cmd_addr(bus_cmd_addr),
    .bus_cmd_wdata(bus_cmd_wdata), .bus_rsp_valid(bus_rsp_valid),
    .fin(fin), .fin_index(fin_index),
    .done(done), .done_index(done_index), .restore_done(restore_done)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_FENCES; g++) begin : g_dirty
      always_ff @(posedge clk) begin
        if (rst) dirty_q[g] <= 1'b0;
        else if (commit_take && req_index == IDX_W'(g)) dirty_q[g] <= 1'b1;
        else if (fin && fin_index == IDX_W'(g)) dirty_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign dirty_mask = dirty_q;

  // R8
  dirty_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !dirty_mask[done_index]);

  // R8
  dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !restore_req) |=> dirty_mask[$past(req_index)]);

  // R10
  restore_last_chk: assert property (@(posedge clk) disable iff (rst)
    restore_done |-> (done && done_index == IDX_W'(NUM_FENCES - 1)));
endmodule

// File: tb/fence_commit_seq_tb.sv
module fence_commit_seq_tb;
  localparam int N = 4;
  localparam int IW = 2;
  localparam logic [15:0] BASE = 16'h4000;

  typedef struct {
    bit          w;
    logic [15:0] a;
    logic [31:0] d;
  } ev_t;

  logic clk = 0;
  logic rst;
  logic req_valid, req_ready, restore_req;
  logic [IW-1:0] req_index;
  logic [63:0] req_desc;
  logic bus_cmd_valid, bus_cmd_ready, bus_cmd_write, bus_rsp_valid;
  logic [15:0] bus_cmd_addr;
  logic [31:0] bus_cmd_wdata;
  logic done, restore_done;
  logic [IW-1:0] done_index;
  logic [N-1:0] dirty_mask;

  always #10 clk = ~clk;

  fence_commit_seq #(.NUM_FENCES(N), .BUS_W(32), .ADDR_W(16), .BASE_ADDR('h4000)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_desc(req_desc), .restore_req(restore_req),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd_ready(bus_cmd_ready),
    .bus_cmd_write(bus_cmd_write), .bus_cmd_addr(bus_cmd_addr),
    .bus_cmd_wdata(bus_cmd_wdata), .bus_rsp_valid(bus_rsp_valid),
    .done(done), .done_index(done_index), .restore_done(restore_done),
    .dirty_mask(dirty_mask)
  );

  int total = 0, bad = 0, cyc = 0;
  ev_t evq[$];
  int fq[$];
  logic [63:0] sh [N];
  logic [N-1:0] mdirty = '0;
  bit busy = 0, restoring = 0, waiting = 0;
  int rd_cnt = 0;
  bit done_exp = 0, rdone_exp = 0;
  int done_idx_exp = 0;
  bit pend = 0;
  int wait_left = 0, rsp_delay = 0, stall_mode = 0;
  logic [7:0] lf = 8'h5a;
  bit stim_req = 0, stim_rst = 0;
  logic [IW-1:0] stim_idx = '0;
  logic [63:0] stim_desc = '0;
  bit pv = 0, pr = 0, pw = 0;
  logic [15:0] pa = '0;
  logic [31:0] pd = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] hi_a(input int i); return BASE + 16'(i * 8); endfunction
  function automatic logic [15:0] lo_a(input int i); return BASE + 16'(i * 8) + 16'd4; endfunction

  task automatic push_fence(input int i, input logic [63:0] d);
    evq.push_back('{1'b1, lo_a(i), 32'h0});
    evq.push_back('{1'b0, lo_a(i), 32'h0});
    evq.push_back('{1'b1, hi_a(i), d[63:32]});
    evq.push_back('{1'b1, lo_a(i), d[31:0]});
    evq.push_back('{1'b0, lo_a(i), 32'h0});
    fq.push_back(i);
  endtask

  task automatic tick();
    ev_t e;
    @(negedge clk);
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog R6", 64'(cyc), 64'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    // compare against model state after the last edge
    chk(req_ready == !busy, "R2 req_ready", 64'(req_ready), 64'(!busy));
    chk(done == done_exp, "R6 done", 64'(done), 64'(done_exp));
    if (done_exp) chk(done_index == IW'(done_idx_exp), "R6 done_index", 64'(done_index), 64'(done_idx_exp));
    chk(restore_done == rdone_exp, "R10 restore_done", 64'(restore_done), 64'(rdone_exp));
    chk(dirty_mask == mdirty, "R8 dirty_mask", 64'(dirty_mask), 64'(mdirty));
    if (waiting || !busy) chk(!bus_cmd_valid, "R4 no cmd while waiting/idle", 64'(bus_cmd_valid), 64'd0);
    if (pv && !pr) chk(bus_cmd_valid && bus_cmd_write == pw && bus_cmd_addr == pa && bus_cmd_wdata == pd,
                       "R7 hold", {bus_cmd_addr, bus_cmd_wdata}, {pa, pd});
    // drive inputs for next edge
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    bus_cmd_ready = (stall_mode == 0) ? 1'b1 : lf[0];
    req_valid = stim_req; req_index = stim_idx; req_desc = stim_desc;
    restore_req = stim_rst;
    bus_rsp_valid = 1'b0;
    if (pend) begin
      if (wait_left == 0) begin bus_rsp_valid = 1'b1; pend = 0; end
      else wait_left--;
    end
    pv = bus_cmd_valid; pr = bus_cmd_ready; pw = bus_cmd_write; pa = bus_cmd_addr; pd = bus_cmd_wdata;
    // predict the next edge
    done_exp = 0; rdone_exp = 0;
    if (!busy && stim_rst) begin
      busy = 1; restoring = 1; stim_rst = 0;
      for (int i = 0; i < N; i++) push_fence(i, sh[i]);
    end else if (!busy && stim_req) begin
      busy = 1; stim_req = 0;
      push_fence(int'(stim_idx), stim_desc);
      sh[stim_idx] = stim_desc;
      mdirty[stim_idx] = 1'b1;
    end
    if (bus_cmd_valid && bus_cmd_ready) begin
      if (evq.size() == 0) chk(1'b0, "R2 unexpected command", {bus_cmd_addr, bus_cmd_wdata}, 64'd0);
      else begin
        e = evq.pop_front();
        chk(bus_cmd_write == e.w, "R3/R4/R5 command kind", 64'(bus_cmd_write), 64'(e.w));
        chk(bus_cmd_addr == e.a, "R3/R5/R6 address", 64'(bus_cmd_addr), 64'(e.a));
        if (e.w) chk(bus_cmd_wdata == e.d, "R5/R9 write data", 64'(bus_cmd_wdata), 64'(e.d));
        if (!e.w) begin waiting = 1; pend = 1; wait_left = rsp_delay; end
      end
    end
    if (bus_rsp_valid) begin
      waiting = 0;
      rd_cnt++;
      if (rd_cnt == 2) begin
        rd_cnt = 0;
        done_exp = 1;
        done_idx_exp = fq.pop_front();
        mdirty[done_idx_exp] = 1'b0;
        if (!restoring) busy = 0;
        else if (done_idx_exp == N - 1) begin rdone_exp = 1; restoring = 0; busy = 0; end
      end
    end
  endtask

  task automatic commit(input int i, input logic [63:0] d);
    stim_idx = IW'(i); stim_desc = d; stim_req = 1;
    while (stim_req) tick();
  endtask

  task automatic wait_idle();
    while (busy || stim_req || stim_rst) tick();
    tick();
  endtask

  initial begin
    rst = 1; req_valid = 0; req_index = '0; req_desc = '0; restore_req = 0;
    bus_cmd_ready = 1; bus_rsp_valid = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(bus_cmd_valid == 1'b0, "R1 bus_cmd_valid", 64'(bus_cmd_valid), 64'd0);
    chk(done == 1'b0 && restore_done == 1'b0, "R1 done", 64'({done, restore_done}), 64'd0);
    chk(dirty_mask == '0, "R1 dirty_mask", 64'(dirty_mask), 64'd0);
    rst = 0;
    tick();
    // plain commit, no stalls
    commit(0, 64'h1234_5678_9abc_def1);
    wait_idle();
    // stalls and slow responses (R7)
    stall_mode = 1; rsp_delay = 2;
    commit(3, 64'hdead_beef_0bad_f00d);
    // back-to-back: second request held while busy (R2)
    rsp_delay = 1;
    commit(1, 64'h0000_0001_ffff_fffe);
    commit(2, 64'h8000_0000_0000_0001);
    wait_idle();
    // clearing descriptor (R9)
    stall_mode = 0; rsp_delay = 0;
    commit(2, 64'h0);
    wait_idle();
    // restore wins over same-cycle commit (R10)
    stall_mode = 1; rsp_delay = 1;
    stim_idx = IW'(1); stim_desc = 64'h5555_aaaa_3333_cccc; stim_req = 1; stim_rst = 1;
    wait_idle();
    // restore again after the new commit landed (R10)
    stim_rst = 1;
    wait_idle();
    chk(evq.size() == 0, "R6 all commands issued", 64'(evq.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule